// File: doc/BRIEF.md
# Snapshot Copy-on-Write Page Tracker

This block sits in the write path of a memory controller while a memory snapshot is being captured. Every CPU or DMA write carries the page frame number it targets. The block compares that frame with the capture progress index, which a snapshot sequencer supplies and which starts at zero when snapshot mode begins. A frame at or above the index has not been captured yet. The first write to such a frame is held with ready low. The block then asks a copy engine to save the frame's page into one slot of a copy-on-write area. The write is released once the engine reports the copy done.

A slot stays reserved until the progress index has moved past the frame it holds, and then it is recycled. The slot area is kept apart from the page cache, so evicting a cached page never discards a saved image. While the sequencer captures a frame, it can ask whether a saved image exists and in which slot, so that it reads the pre-write image and not the live page. Outside snapshot mode, writes pass straight through. Leaving snapshot mode drops every saved slot at once.

Top module: `cow_page_tracker`

## Requirements
- R1: While snapshot mode is low, wr_ready is high for every write and no copy request is raised.
- R2: In snapshot mode, a write whose frame is below the progress index (already captured) is accepted in the same cycle, without a copy.
- R3: In snapshot mode, a write to a frame at or above the index that has no saved slot is held (wr_ready low). One cycle later cpy_req rises, with cpy_frame equal to that frame and cpy_slot naming the slot that was reserved.
- R4: cpy_req, cpy_frame and cpy_slot stay unchanged until cpy_done is sampled high. On the edge that samples cpy_done, cpy_req drops and the slot becomes valid. The held write sees wr_ready high in the next cycle.
- R5: A later write to a frame that already owns a valid slot is accepted at once, and no new copy is started.
- R6: A new copy takes the free slot with the lowest number.
- R7: When every slot holds an uncaptured frame, a write that needs a copy stays held and no request is raised. Once the index passes a saved frame, that slot is freed and then reserved for the waiting write.
- R8: A slot is freed on the first edge at which its frame is below the index. From then on, a lookup of that frame misses.
- R9: lk_hit and lk_slot report, one cycle after lk_frame is presented, whether the frame owns a valid slot and which slot it is. lk_slot is meaningful only when lk_hit is high.
- R10: When snapshot mode goes low, all slots are invalidated on the next edge and any pending copy is abandoned. After snapshot mode is entered again, earlier frames miss on lookup and need a fresh copy.
- R11: After reset, cpy_req and lk_hit are low, and wr_ready is high while no write is offered.
- R12: At most one copy is outstanding. While one is pending, a different uncaptured frame is held, and the pending request keeps its frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snap_mode | input | 1 | High while a snapshot is in progress |
| snap_idx | input | FRAME_W | Capture progress index; frames below it are already captured |
| wr_valid | input | 1 | A write request is offered |
| wr_frame | input | FRAME_W | Page frame number of the offered write |
| wr_ready | output | 1 | The offered write may proceed this cycle |
| cpy_req | output | 1 | Request to save a page into a slot |
| cpy_frame | output | FRAME_W | Frame to be saved |
| cpy_slot | output | SLOT_W | Destination slot of the copy |
| cpy_done | input | 1 | Copy engine finished the pending copy |
| lk_frame | input | FRAME_W | Frame the sequencer is capturing |
| lk_hit | output | 1 | Registered: a saved image exists for lk_frame |
| lk_slot | output | SLOT_W | Registered: slot that holds that image |

## Verification
Several properties are checked on every cycle: writes pass through outside snapshot mode and below the index, a write to the frame being copied is held, the copy request stays stable and drops after done, no request survives the end of snapshot mode, no frame owns two slots, and lookups miss once snapshot mode has ended. Only the bench scenarios can show which slot is chosen (the lowest free one), that a full area stalls until the index frees a slot, that retired frames miss on lookup, and that frames must be copied again after snapshot mode is re-entered.

// File: rtl/cow_pkg.sv
package cow_pkg;
  typedef enum logic [0:0] {
    CP_IDLE = 1'b0,
    CP_BUSY = 1'b1
  } cp_state_e;
endpackage

// File: rtl/cow_slot_table.sv
// Tag table of the copy-on-write slots: valid bits, frame tags,
// parallel compare for the write and lookup ports, free-slot search.
module cow_slot_table #(
  parameter int FRAME_W = 8,
  parameter int SLOTS   = 4,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               snap_mode,
  input  logic [FRAME_W-1:0] snap_idx,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic [FRAME_W-1:0] lk_frame,
  input  logic               fill_en,
  input  logic [SLOT_W-1:0]  fill_slot,
  input  logic [FRAME_W-1:0] fill_frame,
  output logic [SLOTS-1:0]   wr_match,
  output logic [SLOTS-1:0]   lk_match,
  output logic               free_any,
  output logic [SLOT_W-1:0]  free_slot
);

  logic               valid_q [SLOTS];
  logic [FRAME_W-1:0] tag_q   [SLOTS];
  logic [SLOTS-1:0]   free_vec;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic fill_here;
    logic retire_here;

    assign fill_here   = fill_en && (fill_slot == SLOT_W'(g));
    assign retire_here = valid_q[g] && (tag_q[g] < snap_idx);

    // Exit from snapshot mode wins, then a fill, then retirement.
    always_ff @(posedge clk) begin
      if (rst || !snap_mode) begin
        valid_q[g] <= 1'b0;
      end else if (fill_here) begin
        valid_q[g] <= 1'b1;
      end else if (retire_here) begin
        valid_q[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_here) begin
        tag_q[g] <= fill_frame;
      end
    end

    assign wr_match[g] = valid_q[g] && (tag_q[g] == wr_frame);
    assign lk_match[g] = valid_q[g] && (tag_q[g] == lk_frame);
    assign free_vec[g] = !valid_q[g];
  end

  // Lowest-numbered free slot.
  always_comb begin
    free_any  = 1'b0;
    free_slot = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        free_any  = 1'b1;
        free_slot = SLOT_W'(i);
      end
    end
  end

endmodule

// File: rtl/cow_copy_ctl.sv
// Copy handshake: reserves a slot, holds the request until done,
// and then commits the slot to the tag table.
module cow_copy_ctl
  import cow_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int SLOTS   = 4,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               snap_mode,
  input  logic               need_copy,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic               free_any,
  input  logic [SLOT_W-1:0]  free_slot,
  input  logic               cpy_done,
  output logic               cpy_req,
  output logic [FRAME_W-1:0] cpy_frame,
  output logic [SLOT_W-1:0]  cpy_slot,
  output logic               fill_en,
  output logic [SLOT_W-1:0]  fill_slot,
  output logic [FRAME_W-1:0] fill_frame
);

  cp_state_e          state_q;
  logic [FRAME_W-1:0] frame_q;
  logic [SLOT_W-1:0]  slot_q;
  logic               start;

  assign start = (state_q == CP_IDLE) && snap_mode && need_copy && free_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CP_IDLE;
      frame_q <= '0;
      slot_q  <= '0;
    end else begin
      unique case (state_q)
        CP_IDLE: begin
          if (start) begin
            state_q <= CP_BUSY;
            frame_q <= wr_frame;
            slot_q  <= free_slot;
          end
        end
        CP_BUSY: begin
          if (!snap_mode || cpy_done) begin
            state_q <= CP_IDLE;
          end
        end
        default: state_q <= CP_IDLE;
      endcase
    end
  end

  assign cpy_req    = (state_q == CP_BUSY);
  assign cpy_frame  = frame_q;
  assign cpy_slot   = slot_q;
  assign fill_en    = (state_q == CP_BUSY) && snap_mode && cpy_done;
  assign fill_slot  = slot_q;
  assign fill_frame = frame_q;

endmodule

// File: rtl/cow_lookup_reg.sv
// Registered lookup answer for the snapshot sequencer.
module cow_lookup_reg #(
  parameter int SLOTS   = 4,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOTS-1:0]  lk_match,
  output logic              lk_hit,
  output logic [SLOT_W-1:0] lk_slot
);

  logic [SLOT_W-1:0] enc;

  always_comb begin
    enc = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (lk_match[i]) begin
        enc = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit  <= 1'b0;
      lk_slot <= '0;
    end else begin
      lk_hit  <= |lk_match;
      lk_slot <= enc;
    end
  end

endmodule

// File: rtl/cow_page_tracker.sv
module cow_page_tracker #(
  parameter int FRAME_W = 8,
  parameter int SLOTS   = 4,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               snap_mode,
  input  logic [FRAME_W-1:0] snap_idx,
  input  logic               wr_valid,
  input  logic [FRAME_W-1:0] wr_frame,
  output logic               wr_ready,
  output logic               cpy_req,
  output logic [FRAME_W-1:0] cpy_frame,
  output logic [SLOT_W-1:0]  cpy_slot,
  input  logic               cpy_done,
  input  logic [FRAME_W-1:0] lk_frame,
  output logic               lk_hit,
  output logic [SLOT_W-1:0]  lk_slot
);

  logic [SLOTS-1:0]   wr_match;
  logic [SLOTS-1:0]   lk_match;
  logic               free_any;
  logic [SLOT_W-1:0]  free_slot;
  logic               fill_en;
  logic [SLOT_W-1:0]  fill_slot;
  logic [FRAME_W-1:0] fill_frame;
  logic               uncaptured;
  logic               need_copy;

  assign uncaptured = wr_frame >= snap_idx;
  assign need_copy  = snap_mode && wr_valid && uncaptured && !(|wr_match);
  assign wr_ready   = !need_copy;

  cow_slot_table #(.FRAME_W(FRAME_W), .SLOTS(SLOTS)) u_table (
    .clk        (clk),
    .rst        (rst),
    .snap_mode  (snap_mode),
    .snap_idx   (snap_idx),
    .wr_frame   (wr_frame),
    .lk_frame   (lk_frame),
    .fill_en    (fill_en),
    .fill_slot  (fill_slot),
    .fill_frame (fill_frame),
    .wr_match   (wr_match),
    .lk_match   (lk_match),
    .free_any   (free_any),
    .free_slot  (free_slot)
  );

  cow_copy_ctl #(.FRAME_W(FRAME_W), .SLOTS(SLOTS)) u_copy (
    .clk        (clk),
    .rst        (rst),
    .snap_mode  (snap_mode),
    .need_copy  (need_copy),
    .wr_frame   (wr_frame),
    .free_any   (free_any),
    .free_slot  (free_slot),
    .cpy_done   (cpy_done),
    .cpy_req    (cpy_req),
    .cpy_frame  (cpy_frame),
    .cpy_slot   (cpy_slot),
    .fill_en    (fill_en),
    .fill_slot  (fill_slot),
    .fill_frame (fill_frame)
  );

  cow_lookup_reg #(.SLOTS(SLOTS)) u_lookup (
    .clk      (clk),
    .rst      (rst),
    .lk_match (lk_match),
    .lk_hit   (lk_hit),
    .lk_slot  (lk_slot)
  );

endmodule

// File: rtl/cow_page_tracker_chk.sv
module cow_page_tracker_chk #(
  parameter int FRAME_W = 8,
  parameter int SLOTS   = 4,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               snap_mode,
  input logic [FRAME_W-1:0] snap_idx,
  input logic               wr_valid,
  input logic [FRAME_W-1:0] wr_frame,
  input logic               wr_ready,
  input logic               cpy_req,
  input logic [FRAME_W-1:0] cpy_frame,
  input logic [SLOT_W-1:0]  cpy_slot,
  input logic               cpy_done,
  input logic               lk_hit,
  input logic [SLOTS-1:0]   wr_match
);

  AST_PASS_OFF: assert property (@(posedge clk) disable iff (rst)
    !snap_mode |-> wr_ready); // R1

  AST_PASS_CAPTURED: assert property (@(posedge clk) disable iff (rst)
    (snap_mode && wr_valid && (wr_frame < snap_idx)) |-> wr_ready); // R2

  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (rst)
    (cpy_req && snap_mode && wr_valid && (wr_frame == cpy_frame) && (wr_frame >= snap_idx))
      |-> !wr_ready); // R3

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (cpy_req && !cpy_done && snap_mode)
      |=> (cpy_req && $stable(cpy_frame) && $stable(cpy_slot))); // R4

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (cpy_req && cpy_done) |=> !cpy_req); // R4

  AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_match)); // R5

  AST_NO_REQ_OFF: assert property (@(posedge clk) disable iff (rst)
    !snap_mode |=> !cpy_req); // R10

  AST_EXIT_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    (!snap_mode && $past(!snap_mode) && $past(!snap_mode, 2)) |-> !lk_hit); // R10

endmodule

bind cow_page_tracker cow_page_tracker_chk #(.FRAME_W(FRAME_W), .SLOTS(SLOTS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .snap_mode (snap_mode),
  .snap_idx  (snap_idx),
  .wr_valid  (wr_valid),
  .wr_frame  (wr_frame),
  .wr_ready  (wr_ready),
  .cpy_req   (cpy_req),
  .cpy_frame (cpy_frame),
  .cpy_slot  (cpy_slot),
  .cpy_done  (cpy_done),
  .lk_hit    (lk_hit),
  .wr_match  (wr_match)
);

// File: tb/tb_cow_page_tracker.sv
`timescale 1ns/1ps
module tb_cow_page_tracker;
  localparam int FW = 8;
  localparam int NS = 4;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          snap_mode = 1'b0;
  logic [FW-1:0] snap_idx = '0;
  logic          wr_valid = 1'b0;
  logic [FW-1:0] wr_frame = '0;
  logic          wr_ready;
  logic          cpy_req;
  logic [FW-1:0] cpy_frame;
  logic [SW-1:0] cpy_slot;
  logic          cpy_done = 1'b0;
  logic [FW-1:0] lk_frame = '0;
  logic          lk_hit;
  logic [SW-1:0] lk_slot;

  int nvec = 0;
  int nbad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cow_page_tracker #(.FRAME_W(FW), .SLOTS(NS)) dut (
    .clk(clk), .rst(rst), .snap_mode(snap_mode), .snap_idx(snap_idx),
    .wr_valid(wr_valid), .wr_frame(wr_frame), .wr_ready(wr_ready),
    .cpy_req(cpy_req), .cpy_frame(cpy_frame), .cpy_slot(cpy_slot),
    .cpy_done(cpy_done), .lk_frame(lk_frame), .lk_hit(lk_hit), .lk_slot(lk_slot)
  );

  // Row: {snap, idx[8], wv, wf[8], done, lk[8], e_rdy, e_req, e_cslot[2], e_hit, e_lslot[2]}
  // Registered expectations reflect the edge before the row is applied.
  localparam int NV = 17;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 8'd0, 1'b1, 8'd3, 1'b0, 8'd0, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0},
    {1'b1, 8'd0, 1'b1, 8'd5, 1'b0, 8'd5, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0},
    {1'b1, 8'd0, 1'b1, 8'd5, 1'b0, 8'd5, 1'b0, 1'b1, 2'd0, 1'b0, 2'd0},
    {1'b1, 8'd0, 1'b1, 8'd5, 1'b1, 8'd5, 1'b0, 1'b1, 2'd0, 1'b0, 2'd0},
    {1'b1, 8'd0, 1'b1, 8'd5, 1'b0, 8'd5, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0},
    {1'b1, 8'd0, 1'b1, 8'd5, 1'b0, 8'd5, 1'b1, 1'b0, 2'd0, 1'b1, 2'd0},
    {1'b1, 8'd3, 1'b1, 8'd2, 1'b0, 8'd5, 1'b1, 1'b0, 2'd0, 1'b1, 2'd0},
    {1'b1, 8'd3, 1'b1, 8'd9, 1'b0, 8'd9, 1'b0, 1'b0, 2'd0, 1'b1, 2'd0},
    {1'b1, 8'd3, 1'b1, 8'd9, 1'b1, 8'd9, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0},
    {1'b1, 8'd3, 1'b0, 8'd9, 1'b0, 8'd9, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0},
    {1'b1, 8'd3, 1'b0, 8'd9, 1'b0, 8'd9, 1'b1, 1'b0, 2'd0, 1'b1, 2'd1},
    {1'b1, 8'd6, 1'b0, 8'd0, 1'b0, 8'd5, 1'b1, 1'b0, 2'd0, 1'b1, 2'd1},
    {1'b1, 8'd6, 1'b0, 8'd0, 1'b0, 8'd5, 1'b1, 1'b0, 2'd0, 1'b1, 2'd0},
    {1'b1, 8'd6, 1'b0, 8'd0, 1'b0, 8'd5, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0},
    {1'b1, 8'd6, 1'b1, 8'd7, 1'b0, 8'd0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0},
    {1'b1, 8'd6, 1'b1, 8'd7, 1'b1, 8'd0, 1'b0, 1'b1, 2'd0, 1'b0, 2'd0},
    {1'b1, 8'd6, 1'b1, 8'd7, 1'b0, 8'd0, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Save one frame; expects the given slot (R3, R4, R6).
  task automatic do_copy(input logic [FW-1:0] f, input int slot);
    @(negedge clk);
    wr_valid = 1'b1; wr_frame = f; cpy_done = 1'b0;
    #1 chk(wr_ready == 1'b0, "R3 held before copy", wr_ready, 0);
    @(negedge clk);
    #1 chk(cpy_req == 1'b1, "R3 request raised", cpy_req, 1);
    chk(cpy_frame == f, "R3 request frame", cpy_frame, f);
    chk(cpy_slot == SW'(slot), "R6 lowest free slot", cpy_slot, slot);
    cpy_done = 1'b1;
    @(negedge clk);
    cpy_done = 1'b0;
    #1 chk(wr_ready == 1'b1, "R4 released after done", wr_ready, 1);
    chk(cpy_req == 1'b0, "R4 request dropped", cpy_req, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk(cpy_req == 1'b0, "R11 reset request", cpy_req, 0);
    chk(lk_hit == 1'b0, "R11 reset lookup", lk_hit, 0);
    chk(wr_ready == 1'b1, "R11 reset ready", wr_ready, 1);
    rst = 1'b0;

    // Vector table: R1 R2 R3 R4 R5 R6 R8 R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      snap_mode = VEC[i][33];
      snap_idx  = VEC[i][32:25];
      wr_valid  = VEC[i][24];
      wr_frame  = VEC[i][23:16];
      cpy_done  = VEC[i][15];
      lk_frame  = VEC[i][14:7];
      #1;
      chk(wr_ready == VEC[i][6], "R2 R3 R5 ready", wr_ready, VEC[i][6]);
      chk(cpy_req == VEC[i][5], "R4 request", cpy_req, VEC[i][5]);
      if (VEC[i][5]) chk(cpy_slot == VEC[i][4:3], "R6 copy slot", cpy_slot, VEC[i][4:3]);
      chk(lk_hit == VEC[i][2], "R9 R8 lookup hit", lk_hit, VEC[i][2]);
      if (VEC[i][2]) chk(lk_slot == VEC[i][1:0], "R9 lookup slot", lk_slot, VEC[i][1:0]);
    end

    // Fill the remaining slots (slot0=7, slot1=9 held), then overflow: R7
    do_copy(8'd20, 2);
    do_copy(8'd21, 3);
    @(negedge clk);
    wr_valid = 1'b1; wr_frame = 8'd30;
    for (int k = 0; k < 4; k++) begin
      #1 chk(wr_ready == 1'b0 && cpy_req == 1'b0, "R7 stall when full", {wr_ready, cpy_req}, 0);
      @(negedge clk);
    end
    snap_idx = 8'd8;
    @(negedge clk);
    @(negedge clk);
    #1 chk(cpy_req == 1'b1, "R7 request after slot freed", cpy_req, 1);
    chk(cpy_slot == 2'd0, "R7 freed slot reused", cpy_slot, 0);
    chk(cpy_frame == 8'd30, "R7 waiting frame", cpy_frame, 30);
    // A second uncaptured frame while a copy is pending: R12
    @(negedge clk);
    wr_frame = 8'd31;
    #1 chk(wr_ready == 1'b0, "R12 second frame held", wr_ready, 0);
    @(negedge clk);
    #1 chk(cpy_frame == 8'd30, "R12 pending frame kept", cpy_frame, 30);
    wr_frame = 8'd30; cpy_done = 1'b1;
    @(negedge clk);
    cpy_done = 1'b0;
    #1 chk(wr_ready == 1'b1, "R4 release after done", wr_ready, 1);

    // Leave and re-enter snapshot mode: R1 R10
    @(negedge clk);
    snap_mode = 1'b0; wr_frame = 8'd9;
    #1 chk(wr_ready == 1'b1, "R1 pass-through off", wr_ready, 1);
    @(negedge clk);
    #1 chk(cpy_req == 1'b0, "R1 no request off", cpy_req, 0);
    snap_mode = 1'b1; snap_idx = 8'd0; wr_valid = 1'b0; lk_frame = 8'd9;
    @(negedge clk);
    #1 chk(lk_hit == 1'b0, "R10 lookup misses after exit", lk_hit, 0);
    do_copy(8'd9, 0);

    // Abandon a pending copy on exit: R10
    @(negedge clk);
    wr_frame = 8'd40; wr_valid = 1'b1;
    @(negedge clk);
    #1 chk(cpy_req == 1'b1, "R3 request before exit", cpy_req, 1);
    snap_mode = 1'b0;
    @(negedge clk);
    #1 chk(cpy_req == 1'b0, "R10 pending copy abandoned", cpy_req, 0);

    // Reset mid-run: R11
    wr_valid = 1'b0; snap_mode = 1'b1;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1 chk(cpy_req == 1'b0 && lk_hit == 1'b0, "R11 reset outputs", {cpy_req, lk_hit}, 0);
    chk(wr_ready == 1'b1, "R11 ready idle", wr_ready, 1);
    rst = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule